// File: doc/BRIEF.md
# Indexed Bit-Group Instruction Sequencer

This block steps a processor through the machine cycles of a prefixed shift or rotate instruction whose operand lives in memory. On a start request it fetches instruction bytes from consecutive addresses. The first byte decides which of two forms follows.

In the indexed form, the first byte names an index register. After it come the group byte, a signed displacement and the operation byte, in that order. The block adds the sign-extended displacement to the chosen index register to form the effective address. In the register-indirect form, the first byte is the group byte itself, the next byte is the operation byte, and the effective address is a 16-bit pair register. In both forms the block then reads the operand at the effective address and presents it, with the operation byte, to an outside shift unit. It writes the shift unit's result back to the same address.

For every cycle the block reports the bus activity (kind and address), the machine-cycle number and the T state. It raises a done pulse when the instruction ends. The bus, the memory and the shift unit are outside the block.

Top module: `idx_shift_sequencer`

## Requirements
- R1: After reset, and until a start request is accepted, busy and done are low, busKind is 0 (idle), and mCycle and tState are 0.
- R2: A first fetched byte that matches 11N11101 (byte AND 0xDF equals 0xDD) selects the indexed form. Its bit 5 (N) selects idxY when 1 and idxX when 0.
- R3: The indexed form runs 6 machine cycles of 4, 4, 3, 5, 4 and 3 T states (23 in all). Their busKind values are fetch, fetch, read, fetch, read, write, with busKind encoded as 1 fetch, 2 read, 3 write and 0 idle.
- R4: Instruction bytes, including the displacement, come from startAddr, startAddr+1, and so on, one address per machine cycle in fetch order.
- R5: In the indexed form the operand read and the result write both use the index value plus the sign-extended displacement, taken modulo 2^16.
- R6: Any other first byte is taken as the group byte, and the register-indirect form follows. It runs 4 machine cycles of 4, 4, 4 and 3 T states, with kinds fetch, fetch, read, write, and both operand cycles use pairAddr.
- R7: tState counts 1, 2, ... within each machine cycle and restarts at 1 at the next one. mCycle numbers the machine cycles from 1. busStart is high exactly in T1 of each machine cycle.
- R8: Throughout the write cycle, shiftOp holds the last fetched byte (the operation byte) and shiftOperand holds the byte read in the operand cycle. busWrData equals shiftResult.
- R9: done is high for exactly one clock, in the cycle after the last T state of the write cycle. In that cycle busy is low, and a start request is accepted again.
- R10: A start request while busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin an instruction (accepted when idle) |
| startAddr | input | ADDR_W | Address of the first instruction byte |
| idxX | input | ADDR_W | Index register X value |
| idxY | input | ADDR_W | Index register Y value |
| pairAddr | input | ADDR_W | Pair register used by the indirect form |
| busRdData | input | 8 | Byte returned by fetch and read cycles |
| shiftResult | input | 8 | Result from the outside shift unit |
| busKind | output | 2 | 0 idle, 1 fetch, 2 read, 3 write |
| busStart | output | 1 | High in T1 of each machine cycle |
| busAddr | output | ADDR_W | Address of the current machine cycle |
| busWrData | output | 8 | Write data during the write cycle |
| shiftOp | output | 8 | Operation byte for the shift unit |
| shiftOperand | output | 8 | Operand byte for the shift unit |
| mCycle | output | 3 | Current machine cycle number (0 when idle) |
| tState | output | 3 | Current T state (0 when idle) |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with the default ADDR_W of 16. At that width, the effective address can wrap past 0xFFFF, and the most negative displacement, 0x80, can pull the address below the index base. Both cases are run next to random index values. Both index prefixes and the indirect form are mixed at random. Each T state of each instruction is compared with a profile computed in the bench, and a start request is injected mid-instruction to show it is ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_FETCH = 4;
  localparam int LEN_DISP = 3;
  localparam int LEN_OPC_IDX = 5;
  localparam int LEN_OPC_IND = 4;
  localparam int LEN_RDM = 4;
  localparam int LEN_WRM = 3;
  localparam int LEN_MAX = 5;
  localparam int T_W = $clog2(LEN_MAX + 1);
  localparam int STEP_MAX = 6;
  localparam int M_W = $clog2(STEP_MAX + 1);
  localparam logic [BYTE_W-1:0] PFX_MASK = 8'hDF;
  localparam logic [BYTE_W-1:0] PFX_CODE = 8'hDD;
  localparam int PFX_SEL_BIT = 5;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_READ  = 2'd2,
    BUS_WRITE = 2'd3
  } busKindT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_GRP, ST_DISP, ST_OPC, ST_RDM, ST_WRM
  } stepT;

  typedef struct packed {
    logic ldPc;
    logic incPc;
    logic ldPrefix;
    logic ldDisp;
    logic ldOp;
    logic ldEaIdx;
    logic ldEaPair;
    logic ldOperand;
    logic useEa;
    logic drvWr;
  } strobeT;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           startReq,
  input  logic           firstIsPrefix,
  output strobeT         strobe,
  output logic [1:0]     busKind,
  output logic           busStart,
  output logic [M_W-1:0] mCycle,
  output logic [T_W-1:0] tState,
  output logic           busy,
  output logic           done
);
  stepT           step;
  logic [T_W-1:0] tCnt;
  logic [M_W-1:0] mCnt;
  logic           indexed;
  logic           doneQ;
  logic [T_W-1:0] curLen;
  logic           lastT;

  always_comb begin
    case (step)
      ST_FIRST, ST_GRP: curLen = T_W'(LEN_FETCH);
      ST_DISP:          curLen = T_W'(LEN_DISP);
      ST_OPC:           curLen = indexed ? T_W'(LEN_OPC_IDX) : T_W'(LEN_OPC_IND);
      ST_RDM:           curLen = T_W'(LEN_RDM);
      ST_WRM:           curLen = T_W'(LEN_WRM);
      default:          curLen = '0;
    endcase
  end

  assign lastT = (step != ST_IDLE) && (tCnt == curLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= ST_IDLE;
      tCnt    <= '0;
      mCnt    <= '0;
      indexed <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (step == ST_IDLE) begin
        if (startReq) begin
          step    <= ST_FIRST;
          tCnt    <= T_W'(1);
          mCnt    <= M_W'(1);
          indexed <= 1'b0;
        end
      end else if (lastT) begin
        tCnt <= T_W'(1);
        mCnt <= mCnt + M_W'(1);
        case (step)
          ST_FIRST: begin
            indexed <= firstIsPrefix;
            step    <= firstIsPrefix ? ST_GRP : ST_OPC;
          end
          ST_GRP:  step <= ST_DISP;
          ST_DISP: step <= ST_OPC;
          ST_OPC:  step <= ST_RDM;
          ST_RDM:  step <= ST_WRM;
          default: begin
            step  <= ST_IDLE;
            tCnt  <= '0;
            mCnt  <= '0;
            doneQ <= 1'b1;
          end
        endcase
      end else begin
        tCnt <= tCnt + T_W'(1);
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.ldPc      = (step == ST_IDLE) && startReq;
    strobe.incPc     = lastT && (step inside {ST_FIRST, ST_GRP, ST_DISP, ST_OPC});
    strobe.ldPrefix  = lastT && (step == ST_FIRST);
    strobe.ldDisp    = lastT && (step == ST_DISP);
    strobe.ldOp      = lastT && (step == ST_OPC);
    strobe.ldEaIdx   = lastT && (step == ST_OPC) && indexed;
    strobe.ldEaPair  = lastT && (step == ST_OPC) && !indexed;
    strobe.ldOperand = lastT && (step == ST_RDM);
    strobe.useEa     = (step == ST_RDM) || (step == ST_WRM);
    strobe.drvWr     = (step == ST_WRM);
  end

  always_comb begin
    case (step)
      ST_FIRST, ST_GRP, ST_OPC: busKind = BUS_FETCH;
      ST_DISP, ST_RDM:          busKind = BUS_READ;
      ST_WRM:                   busKind = BUS_WRITE;
      default:                  busKind = BUS_IDLE;
    endcase
  end

  assign busy     = (step != ST_IDLE);
  assign busStart = busy && (tCnt == T_W'(1));
  assign mCycle   = mCnt;
  assign tState   = tCnt;
  assign done     = doneQ;
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] idxX,
  input  logic [ADDR_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pairAddr,
  input  logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] shiftResult,
  output logic              firstIsPrefix,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] shiftOp,
  output logic [BYTE_W-1:0] shiftOperand
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] pcCur;
  logic [ADDR_W-1:0] ea;
  logic [BYTE_W-1:0] disp;
  logic [BYTE_W-1:0] opByte;
  logic [BYTE_W-1:0] operand;
  logic              selY;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] idxSel;

  assign firstIsPrefix = ((rdData & PFX_MASK) == PFX_CODE);
  assign dispExt       = {{EXT_W{disp[BYTE_W-1]}}, disp};
  assign idxSel        = selY ? idxY : idxX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcCur   <= '0;
      ea      <= '0;
      disp    <= '0;
      opByte  <= '0;
      operand <= '0;
      selY    <= 1'b0;
    end else begin
      if (strobe.ldPc)           pcCur   <= startAddr;
      else if (strobe.incPc)     pcCur   <= pcCur + ADDR_W'(1);
      if (strobe.ldPrefix)       selY    <= rdData[PFX_SEL_BIT];
      if (strobe.ldDisp)         disp    <= rdData;
      if (strobe.ldOp)           opByte  <= rdData;
      if (strobe.ldEaIdx)        ea      <= idxSel + dispExt;
      else if (strobe.ldEaPair)  ea      <= pairAddr;
      if (strobe.ldOperand)      operand <= rdData;
    end
  end

  assign busAddr      = strobe.useEa ? ea : pcCur;
  assign wrData       = strobe.drvWr ? shiftResult : '0;
  assign shiftOp      = opByte;
  assign shiftOperand = operand;
endmodule

// File: rtl/idx_shift_sequencer.sv
module idx_shift_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] idxX,
  input  logic [ADDR_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pairAddr,
  input  logic [7:0]        busRdData,
  input  logic [7:0]        shiftResult,
  output logic [1:0]        busKind,
  output logic              busStart,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic [7:0]        shiftOp,
  output logic [7:0]        shiftOperand,
  output logic [2:0]        mCycle,
  output logic [2:0]        tState,
  output logic              busy,
  output logic              done
);
  strobeT strobe;
  logic   firstIsPrefix;

  seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .firstIsPrefix(firstIsPrefix),
    .strobe       (strobe),
    .busKind      (busKind),
    .busStart     (busStart),
    .mCycle       (mCycle),
    .tState       (tState),
    .busy         (busy),
    .done         (done)
  );

  seq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .startAddr    (startAddr),
    .idxX         (idxX),
    .idxY         (idxY),
    .pairAddr     (pairAddr),
    .rdData       (busRdData),
    .shiftResult  (shiftResult),
    .firstIsPrefix(firstIsPrefix),
    .busAddr      (busAddr),
    .wrData       (busWrData),
    .shiftOp      (shiftOp),
    .shiftOperand (shiftOperand)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busKind,
  input logic              busStart,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        shiftOp,
  input logic [7:0]        shiftOperand,
  input logic [2:0]        mCycle,
  input logic [2:0]        tState,
  input logic              busy,
  input logic              done
);
  assert_tstate_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tState >= 3'd1 && tState <= 3'd5));

  assert_tstate_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tState != 3'd1) |-> (tState == $past(tState) + 3'd1));

  assert_mcycle_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busStart && mCycle != 3'd1) |-> (mCycle == $past(mCycle) + 3'd1));

  assert_bus_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> (busy && tState == 3'd1));

  assert_kind_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busKind != 2'd0) == busy);

  assert_write_same_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busKind == 2'd3 && tState == 3'd1) |-> (busAddr == $past(busAddr) && $past(busKind) == 2'd2));

  assert_write_inputs_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busKind == 2'd3 && tState != 3'd1) |-> ($stable(shiftOp) && $stable(shiftOperand)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && busKind == 2'd0));
endmodule

bind idx_shift_sequencer seq_checker #(.ADDR_W(ADDR_W)) u_seq_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busKind     (busKind),
  .busStart    (busStart),
  .busAddr     (busAddr),
  .shiftOp     (shiftOp),
  .shiftOperand(shiftOperand),
  .mCycle      (mCycle),
  .tState      (tState),
  .busy        (busy),
  .done        (done)
);

// File: tb/test_idx_shift_sequencer.sv
`timescale 1ns/100ps
module test_idx_shift_sequencer;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] idxX = '0;
  logic [AW-1:0] idxY = '0;
  logic [AW-1:0] pairAddr = '0;
  logic [7:0]    busRdData;
  logic [7:0]    shiftResult;
  logic [1:0]    busKind;
  logic          busStart;
  logic [AW-1:0] busAddr;
  logic [7:0]    busWrData;
  logic [7:0]    shiftOp;
  logic [7:0]    shiftOperand;
  logic [2:0]    mCycle;
  logic [2:0]    tState;
  logic          busy;
  logic          done;

  int checks = 0;
  int errors = 0;

  logic [7:0]    prog [4];
  logic [AW-1:0] eaB = '0;
  logic [7:0]    memOp = '0;

  always #2.5 clk = ~clk;

  idx_shift_sequencer #(.ADDR_W(AW)) i_idx_shift_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .idxX(idxX), .idxY(idxY), .pairAddr(pairAddr), .busRdData(busRdData),
    .shiftResult(shiftResult), .busKind(busKind), .busStart(busStart),
    .busAddr(busAddr), .busWrData(busWrData), .shiftOp(shiftOp),
    .shiftOperand(shiftOperand), .mCycle(mCycle), .tState(tState),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] shiftModel(input logic [7:0] op, input logic [7:0] v);
    return {v[0], v[7:1]} ^ op;
  endfunction

  always_comb begin
    if (busAddr == startAddr)                 busRdData = prog[0];
    else if (busAddr == startAddr + 16'd1)    busRdData = prog[1];
    else if (busAddr == startAddr + 16'd2)    busRdData = prog[2];
    else if (busAddr == startAddr + 16'd3)    busRdData = prog[3];
    else if (busAddr == eaB)                  busRdData = memOp;
    else                                      busRdData = 8'h5A;
  end

  assign shiftResult = shiftModel(shiftOp, shiftOperand);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runInstr(input logic indexed, input logic useY, input logic [7:0] d,
                          input logic [7:0] opc, input logic [AW-1:0] x, input logic [AW-1:0] y,
                          input logic [AW-1:0] hl, input logic [AW-1:0] pc,
                          input logic [7:0] operand, input logic midStart);
    int lens [6];
    logic [1:0] kinds [6];
    logic useEa [6];
    int n;
    int fetchIdx;
    logic [AW-1:0] addrExp;
    string tagT;
    string tagA;
    logic [AW-1:0] idxV;
    idxV = useY ? y : x;
    if (indexed) begin
      eaB = idxV + {{8{d[7]}}, d};
      prog[0] = useY ? 8'hFD : 8'hDD; prog[1] = 8'hCB; prog[2] = d; prog[3] = opc;
      n = 6;
      lens  = '{4, 4, 3, 5, 4, 3};
      kinds = '{2'd1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd3};
      useEa = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      tagT = "R3/R7"; tagA = "R5 (index select R2)";
    end else begin
      eaB = hl;
      prog[0] = 8'hCB; prog[1] = opc; prog[2] = 8'h00; prog[3] = 8'h00;
      n = 4;
      lens  = '{4, 4, 4, 3, 0, 0};
      kinds = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0};
      useEa = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      tagT = "R6/R7"; tagA = "R6";
    end
    if (eaB - pc < 16'd4 || pc - eaB < 16'd4) pc = eaB + 16'd64;
    memOp = operand;
    idxX = x; idxY = y; pairAddr = hl; startAddr = pc;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    fetchIdx = 0;
    for (int m = 0; m < n; m++) begin
      addrExp = useEa[m] ? eaB : pc + AW'(fetchIdx);
      for (int t = 1; t <= lens[m]; t++) begin
        chk(busKind == kinds[m] && mCycle == 3'(m + 1) && tState == 3'(t) &&
            busStart == (t == 1) && busy, tagT,
            {busKind, mCycle, tState, busStart, busy}, {kinds[m], 3'(m + 1), 3'(t), t == 1, 1'b1});
        chk(busAddr == addrExp, useEa[m] ? tagA : "R4", 64'(busAddr), 64'(addrExp));
        if (kinds[m] == 2'd3)
          chk(shiftOp == opc && shiftOperand == operand &&
              busWrData == shiftModel(opc, operand), "R8",
              {shiftOp, shiftOperand, busWrData}, {opc, operand, shiftModel(opc, operand)});
        if (midStart && m == 2 && t == 1) startReq = 1'b1;   // R10: ignored while busy
        else startReq = 1'b0;
        @(negedge clk);
      end
      if (!useEa[m]) fetchIdx++;
    end
    chk(done && !busy && busKind == 2'd0, "R9 done pulse", {done, busy, busKind}, {1'b1, 1'b0, 2'd0});
    @(negedge clk);
    chk(!done && !busy, "R9 single pulse / R10 no restart", {done, busy}, {1'b0, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && busKind == 2'd0 && mCycle == 3'd0 && tState == 3'd0, "R1 reset",
        {busy, done, busKind, mCycle, tState}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && busKind == 2'd0, "R1 idle after reset", {busy, done, busKind}, 64'd0);
    // directed corners
    runInstr(1'b1, 1'b0, 8'h80, 8'h1E, 16'h1000, 16'h2000, 16'h3000, 16'h0100, 8'hA5, 1'b0);
    runInstr(1'b1, 1'b1, 8'h7F, 8'h26, 16'h1000, 16'h2000, 16'h3000, 16'h0200, 8'h3C, 1'b1);
    runInstr(1'b1, 1'b1, 8'h20, 8'h2E, 16'h1000, 16'hFFF0, 16'h3000, 16'h0300, 8'h81, 1'b0);
    runInstr(1'b0, 1'b0, 8'h00, 8'h3E, 16'h1000, 16'h2000, 16'hFFFF, 16'h0400, 8'h01, 1'b1);
    runInstr(1'b1, 1'b0, 8'h00, 8'h16, 16'h0000, 16'h2000, 16'h3000, 16'h8000, 8'hFF, 1'b0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      runInstr(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
      if (($urandom % 3) == 0) @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule